// File: doc/BRIEF.md
# Inbound Address Window Translator

This block sits on the inbound path from an expansion bus into the local system bus. It holds two programmable target windows. Each window has a size mask, a local-side base and a host-visible base. Each incoming 32-bit memory address is compared against both windows. On a hit, the address is rebuilt in local address space: the high bits come from the window's local base and the offset bits below the window size pass through unchanged.

A small synchronous register port programs the windows. Each write is tagged as coming either from the host side or from the local processor. Base writes from the host are refused until the local side opens host configuration. The local side can therefore fix the window sizes before the host probes the bases. Window sizes are powers of two from 4 KB to 4 GB. The base read-back hides the bits below the size, so a host can find the size by writing all ones and reading the value back.

Lookups are registered. The hit flag, the window number (1 or 2) and the translated address appear one clock after the address is presented.

Top module: `inb_win_xlate`

## Requirements
- R1: After reset, every lookup misses and the registers read as follows:
  - register 0 reads 0;
  - both size masks read 0xFFFFF000 (4 KB);
  - both local bases read 0;
  - both host bases read 0.
- R2: Register map on `regAddr`:
  - 0: control. Bit 0 is the memory enable, bit 1 is the window-2 enable, bit 2 is the host-config enable. Bits 31:3 read 0.
  - 1, 2, 3: window 1 mask, local base, host base.
  - 4, 5, 6: window 2 mask, local base, host base.
  - Bits 11:0 of every mask and base read 0.
  - Writes with `regWrHost`=0 always take effect.
- R3: A written mask is stored in normalized form. Bit i (12..31) is kept as 1 only if every written bit from 31 down to i is 1, and bits 11:0 are 0. A non-contiguous value therefore becomes the next legal larger window, and 0 gives a 4 GB window.
- R4: A host base reads back as the stored base ANDed with the window's current mask. Writing 0xFFFFFFFF therefore reads back the mask.
- R5: A host write (`regWrHost`=1) to a host base is ignored while the host-config enable is 0. Host writes to the other registers take effect.
- R6: Window 1 matches when the memory enable is 1 and (addr AND mask) equals (base AND mask). Window 2 also needs the window-2 enable. With the memory enable at 0, nothing hits.
- R7: On a hit, xlAddr = (local base AND mask) OR (addr AND NOT mask). Bits 11:0 always pass through.
- R8: If both windows match, window 1 is reported.
- R9: `outValid`, `hit`, `hitWin` and `xlAddr` reflect the address sampled with `inValid` at the previous clock edge. With no valid input, `outValid` and `hit` are 0.
- R10: A register write and a lookup in the same cycle: the lookup uses the register contents from before that write.
- R11: `hitWin` is 1 or 2 on a hit and 0 on a miss, and `xlAddr` is 0 on a miss. Register 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrHost | input | 1 | 1: write issued from host side, 0: local processor |
| regAddr | input | 3 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| inValid | input | 1 | Incoming address valid |
| inAddr | input | 32 | Incoming bus memory address |
| outValid | output | 1 | Lookup result valid |
| hit | output | 1 | Address fell inside an enabled window |
| hitWin | output | 2 | Matching window: 1, 2, or 0 on miss |
| xlAddr | output | 32 | Translated local address, 0 on miss |

## Verification
A register write and an address lookup can land in the same clock. In that case the lookup must use the window setup from before the write, not a mix of old and new. The bench provokes this by moving window 1's host base away from the address being looked up in the very cycle of the lookup. It then expects that lookup to resolve to window 1 under the old base. A second lookup of the same address must then fall through to window 2, and a lookup at the new base must return to window 1.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;
  localparam int ADDR_W       = 32;
  localparam int PAGE_BITS    = 12;
  localparam int HI_W         = ADDR_W - PAGE_BITS;
  localparam int NUM_WIN      = 2;
  localparam int REGS_PER_WIN = 3;
  localparam int REG_AW       = 3;
  localparam int WIN_IDX_W    = $clog2(NUM_WIN + 1);
  localparam logic [REG_AW-1:0] CTRL_IDX = '0;

  // Configuration handed from the control side to the datapath.
  typedef struct packed {
    logic [NUM_WIN-1:0]           winOn;
    logic [NUM_WIN-1:0][HI_W-1:0] mask;
    logic [NUM_WIN-1:0][HI_W-1:0] lbase;
    logic [NUM_WIN-1:0][HI_W-1:0] bar;
  } cfgBus_t;

  // Keep only the leading run of ones: the nearest legal size not smaller.
  function automatic logic [HI_W-1:0] normMask(input logic [HI_W-1:0] raw);
    logic [HI_W-1:0] res;
    logic run;
    run = 1'b1;
    for (int i = HI_W - 1; i >= 0; i--) begin
      run    = run & raw[i];
      res[i] = run;
    end
    return res;
  endfunction
endpackage

// File: rtl/inb_win_ctrl.sv
module inb_win_ctrl
  import inb_win_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regWrHost,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [ADDR_W-1:0]   regWrData,
  output logic [ADDR_W-1:0]   regRdData,
  output cfgBus_t             cfg
);
  logic memEn, win2En, hostCfgEn;
  logic [NUM_WIN-1:0][HI_W-1:0] maskR, lbaseR, barR;
  logic barWrOk;

  assign barWrOk = !regWrHost || hostCfgEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memEn     <= 1'b0;
      win2En    <= 1'b0;
      hostCfgEn <= 1'b0;
    end else if (regWrEn && regAddr == CTRL_IDX) begin
      memEn     <= regWrData[0];
      win2En    <= regWrData[1];
      hostCfgEn <= regWrData[2];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [REG_AW-1:0] MASK_IDX = REG_AW'(1 + REGS_PER_WIN * w);
    localparam logic [REG_AW-1:0] LB_IDX   = REG_AW'(2 + REGS_PER_WIN * w);
    localparam logic [REG_AW-1:0] BAR_IDX  = REG_AW'(3 + REGS_PER_WIN * w);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR[w]  <= '1;
        lbaseR[w] <= '0;
        barR[w]   <= '0;
      end else if (regWrEn) begin
        if (regAddr == MASK_IDX) maskR[w]  <= normMask(regWrData[ADDR_W-1:PAGE_BITS]);
        if (regAddr == LB_IDX)   lbaseR[w] <= regWrData[ADDR_W-1:PAGE_BITS];
        if (regAddr == BAR_IDX && barWrOk) barR[w] <= regWrData[ADDR_W-1:PAGE_BITS];
      end
    end

    // R5: refused host write leaves the base untouched
    a_r5_host_bar_hold: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regWrHost && !hostCfgEn && regAddr == BAR_IDX) |=> $stable(barR[w]));

    // R3: stored mask is always a contiguous high-order run of ones
    a_r3_mask_contig: assert property (@(posedge clk) disable iff (!rstN)
      ((~maskR[w]) & ((~maskR[w]) + HI_W'(1))) == '0);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_IDX) regRdData[2:0] = {hostCfgEn, win2En, memEn};
    for (int w = 0; w < NUM_WIN; w++) begin
      if (regAddr == REG_AW'(1 + REGS_PER_WIN * w)) regRdData = {maskR[w], PAGE_BITS'(0)};
      if (regAddr == REG_AW'(2 + REGS_PER_WIN * w)) regRdData = {lbaseR[w], PAGE_BITS'(0)};
      if (regAddr == REG_AW'(3 + REGS_PER_WIN * w)) regRdData = {barR[w] & maskR[w], PAGE_BITS'(0)};
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++)
      cfg.winOn[w] = memEn && ((w == 0) || win2En);
    cfg.mask  = maskR;
    cfg.lbase = lbaseR;
    cfg.bar   = barR;
  end
endmodule

// File: rtl/inb_win_dp.sv
module inb_win_dp
  import inb_win_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [ADDR_W-1:0]    inAddr,
  input  cfgBus_t              cfg,
  output logic                 outValid,
  output logic                 hit,
  output logic [WIN_IDX_W-1:0] hitWin,
  output logic [ADDR_W-1:0]    xlAddr
);
  logic [NUM_WIN-1:0]           hitVec;
  logic [NUM_WIN-1:0][HI_W-1:0] xlHi;
  logic                         selHit;
  logic [WIN_IDX_W-1:0]         selIdx;
  logic [ADDR_W-1:0]            selAddr;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hitVec[w] = cfg.winOn[w] &&
      (((inAddr[ADDR_W-1:PAGE_BITS] ^ cfg.bar[w]) & cfg.mask[w]) == '0);
    assign xlHi[w] = (cfg.lbase[w] & cfg.mask[w]) |
                     (inAddr[ADDR_W-1:PAGE_BITS] & ~cfg.mask[w]);
  end

  // Descending scan: the lowest-numbered window is applied last and wins.
  always_comb begin
    selHit  = 1'b0;
    selIdx  = '0;
    selAddr = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        selHit  = 1'b1;
        selIdx  = WIN_IDX_W'(w + 1);
        selAddr = {xlHi[w], inAddr[PAGE_BITS-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      hit      <= 1'b0;
      hitWin   <= '0;
      xlAddr   <= '0;
    end else begin
      outValid <= inValid;
      hit      <= inValid && selHit;
      hitWin   <= inValid ? selIdx : '0;
      xlAddr   <= (inValid && selHit) ? selAddr : '0;
    end
  end

  // R9: result follows a valid input by one clock
  a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !hit));
  // R11: index 0 never reported with a hit; misses are clean
  a_r11_idx_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitWin != '0));
  a_r11_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitWin == '0 && xlAddr == '0));
  // R6: memory enable off blocks every window
  a_r6_mem_gate: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cfg.winOn[0]) |=> !hit);
  // R7: page offset passes straight through
  a_r7_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (xlAddr[PAGE_BITS-1:0] == $past(inAddr[PAGE_BITS-1:0])));
endmodule

// File: rtl/inb_win_xlate.sv
module inb_win_xlate
  import inb_win_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regWrHost,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [ADDR_W-1:0]    regWrData,
  output logic [ADDR_W-1:0]    regRdData,
  input  logic                 inValid,
  input  logic [ADDR_W-1:0]    inAddr,
  output logic                 outValid,
  output logic                 hit,
  output logic [WIN_IDX_W-1:0] hitWin,
  output logic [ADDR_W-1:0]    xlAddr
);
  cfgBus_t cfgBus;

  inb_win_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrHost (regWrHost),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfg       (cfgBus)
  );

  inb_win_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inAddr   (inAddr),
    .cfg      (cfgBus),
    .outValid (outValid),
    .hit      (hit),
    .hitWin   (hitWin),
    .xlAddr   (xlAddr)
  );
endmodule

// File: tb/sim_inb_win_xlate.sv
module sim_inb_win_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regWrHost = 1'b0, inValid = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, inAddr = '0;
  logic [31:0] regRdData, xlAddr;
  logic        outValid, hit;
  logic [1:0]  hitWin;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // {address, expHit, expWin, expXl}
  localparam logic [66:0] VEC [NVEC] = '{
    {32'h8000_1234, 1'b1, 2'd1, 32'h0010_1234},
    {32'h8001_0040, 1'b1, 2'd2, 32'h4001_0040},
    {32'h800F_FFFF, 1'b1, 2'd2, 32'h400F_FFFF},
    {32'h8010_0000, 1'b0, 2'd0, 32'h0000_0000},
    {32'h8000_FFFF, 1'b1, 2'd1, 32'h0010_FFFF},
    {32'h0000_0000, 1'b0, 2'd0, 32'h0000_0000},
    {32'h7FFF_FFFF, 1'b0, 2'd0, 32'h0000_0000}
  };

  inb_win_xlate u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrHost(regWrHost),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .inValid(inValid), .inAddr(inAddr), .outValid(outValid), .hit(hit),
    .hitWin(hitWin), .xlAddr(xlAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d, input logic host);
    @(negedge clk);
    regWrEn = 1'b1; regWrHost = host; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, {4'h0, regRdData}, {4'h0, exp});
  endtask

  // result packed as {outValid, hit, hitWin, xlAddr}
  task automatic look(input logic [31:0] a, input logic h, input logic [1:0] w,
                      input logic [31:0] x, input string tag);
    @(negedge clk);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
    chk(tag, {1'b0, outValid, hit, hitWin, xlAddr}, {1'b0, 1'b1, h, w, x});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle outputs", {2'b0, outValid, hit, 32'h0}, 36'h0);
    regRd(3'd0, 32'h0, "R1 ctrl reset");
    regRd(3'd1, 32'hFFFF_F000, "R1 mask1 reset");
    regRd(3'd4, 32'hFFFF_F000, "R1 mask2 reset");
    regRd(3'd2, 32'h0, "R1 lbase1 reset");
    regRd(3'd3, 32'h0, "R1 bar1 reset");
    regRd(3'd6, 32'h0, "R1 bar2 reset");
    look(32'h0000_0000, 1'b0, 2'd0, 32'h0, "R1 R6 no hit with memory enable off");

    // R11 reserved register
    regWr(3'd7, 32'hFFFF_FFFF, 1'b0);
    regRd(3'd7, 32'h0, "R11 reserved reads zero");
    regRd(3'd0, 32'h0, "R11 reserved write no side effect");

    // R3 mask normalization
    regWr(3'd4, 32'hFF0F_F123, 1'b0);
    regRd(3'd4, 32'hFF00_0000, "R3 non-contiguous mask");
    regWr(3'd4, 32'h0, 1'b0);
    regRd(3'd4, 32'h0, "R3 4GB mask");
    regWr(3'd4, 32'hFFFF_FFFF, 1'b0);
    regRd(3'd4, 32'hFFFF_F000, "R3 4KB mask");

    // R5 host base write gating
    regWr(3'd3, 32'h1234_5678, 1'b1);
    regRd(3'd3, 32'h0, "R5 host bar write ignored");
    regWr(3'd3, 32'h9000_0000, 1'b0);
    regRd(3'd3, 32'h9000_0000, "R5 R2 local bar write");
    regWr(3'd0, 32'h7, 1'b1);
    regRd(3'd0, 32'h7, "R5 R2 host ctrl write");

    // R4 size discovery
    regWr(3'd1, 32'hFFFF_0000, 1'b0);
    regWr(3'd3, 32'hFFFF_FFFF, 1'b1);
    regRd(3'd3, 32'hFFFF_0000, "R4 bar readback masked");

    // setup
    regWr(3'd3, 32'h8000_0000, 1'b1);
    regWr(3'd2, 32'h0010_0abc, 1'b0);
    regWr(3'd4, 32'hFFF0_0000, 1'b0);
    regWr(3'd5, 32'h4000_0000, 1'b0);
    regWr(3'd6, 32'h8000_0000, 1'b1);
    regRd(3'd2, 32'h0010_0000, "R2 lbase low bits zero");

    // R6 R7 R8 vector table
    for (int i = 0; i < NVEC; i++) begin
      look(VEC[i][66:35], VEC[i][34], VEC[i][33:32], VEC[i][31:0],
           $sformatf("R6 R7 R8 vector %0d", i));
    end

    // R6 window 2 enable and memory enable
    regWr(3'd0, 32'h5, 1'b0);
    look(32'h8001_0040, 1'b0, 2'd0, 32'h0, "R6 window 2 disabled");
    look(32'h8000_0010, 1'b1, 2'd1, 32'h0010_0010, "R6 window 1 always on");
    regWr(3'd0, 32'h4, 1'b0);
    look(32'h8000_0010, 1'b0, 2'd0, 32'h0, "R6 memory enable off");
    regWr(3'd0, 32'h7, 1'b0);

    // R10 write and lookup in the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regWrHost = 1'b0; regAddr = 3'd3; regWrData = 32'h9000_0000;
    inValid = 1'b1; inAddr = 32'h8000_0020;
    @(negedge clk);
    regWrEn = 1'b0; inValid = 1'b0;
    chk("R10 lookup uses old base", {1'b0, outValid, hit, hitWin, xlAddr},
        {1'b0, 1'b1, 1'b1, 2'd1, 32'h0010_0020});
    look(32'h8000_0020, 1'b1, 2'd2, 32'h4000_0020, "R10 R8 next lookup sees new base");
    look(32'h9000_0020, 1'b1, 2'd1, 32'h0010_0020, "R10 new base hits window 1");

    // R9 idle after a lookup
    @(negedge clk);
    chk("R9 outputs drop without valid", {2'b0, outValid, hit, hitWin, xlAddr}, 36'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule